// File: doc/BRIEF.md
# Bridge Delayed-Transaction Discard Timer

A bridge between two buses holds a completed delayed transaction until the master that asked for it comes back to collect it. If that master never returns, the buffered completion would stay there for good. This unit has one watchdog per bus side, primary and secondary. Each watchdog is armed by a start strobe when a completion is parked and disarmed by a collect strobe when the master takes the completion. If a watchdog runs out first, it pulses a discard output so that the buffering logic can free the entry.

A 16-bit bridge-control register sets the run-time policy. Each side can use a long timeout (2^15 clocks) or a short one (2^10 clocks). The register also holds a sticky timeout flag that software clears by writing one to it, an enable that turns a timeout into a system-error request, and an enable that passes system errors from the secondary bus through to the same request output.

Top module: `brdg_discard_timer`

## Requirements
- R1: After reset, `ctl_rd_data` reads 0 and `pri_discard`, `sec_discard` and `serr_req` are low.
- R2: A write stores bits 1, 8, 9 and 11 of `ctl_wr_data`. Bit 10 reads as the timeout flag. Every other bit reads 0, whatever value was written.
- R3: With bit 8 = 1, `pri_discard` goes high for exactly one cycle, right after the 1024th rising edge that follows the edge that sampled `pri_start`.
- R4: With the select bit = 0, the timeout is 32768 edges instead of 1024.
- R5: The secondary timer takes its select from bit 9 and runs independently of the primary timer.
- R6: A collect strobe stops its timer with no discard, even when it arrives on the edge at which the timer would expire. A start strobe while the timer is running restarts the count.
- R7: After an expiry the timer is idle and gives no further discard until the next start strobe.
- R8: An expiry on either side sets the flag (bit 10) on the same edge that raises the discard output.
- R9: Writing 1 to bit 10 clears the flag. Writing 0 to bit 10 leaves it unchanged. If an expiry and a clearing write fall on the same edge, the flag stays set.
- R10: `serr_req` pulses for one cycle together with a discard pulse only when bit 11 is 1.
- R11: A high `sec_serr_in` drives `serr_req` high one cycle later only when bit 1 is 1.
- R12: Changing a select bit while its timer runs does not change the current count. The new value is used from the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the control register |
| ctl_wr_data | input | 16 | Write data for the control register |
| ctl_rd_data | output | 16 | Control register read value |
| pri_start | input | 1 | Primary completion parked, arm timer |
| pri_collect | input | 1 | Primary completion taken, disarm timer |
| sec_start | input | 1 | Secondary completion parked, arm timer |
| sec_collect | input | 1 | Secondary completion taken, disarm timer |
| sec_serr_in | input | 1 | System error seen on the secondary bus |
| pri_discard | output | 1 | One-cycle primary discard pulse |
| sec_discard | output | 1 | One-cycle secondary discard pulse |
| serr_req | output | 1 | One-cycle system-error request |

## Verification
A wrong counter load or a missed decrement moves the discard pulse off its exact edge. That shows up on the first expiry, 1024 or 32768 cycles after start, so every expiry test samples the cycle just before the expected edge as well as the edge itself. A running bit that stays set after expiry or collect shows up as a second, unexpected discard, which the bench catches by counting pulses over a further window. Flag and error-enable faults show up in `ctl_rd_data` and `serr_req` in the cycle after the write or expiry that should have changed them.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int unsigned FWD_BIT  = 1;
  localparam int unsigned PSEL_BIT = 8;
  localparam int unsigned SSEL_BIT = 9;
  localparam int unsigned FLAG_BIT = 10;
  localparam int unsigned SERR_BIT = 11;

  // terminal count for a run: span minus one
  function automatic int unsigned span_m1(input logic sel_short,
                                          input int unsigned long_exp,
                                          input int unsigned short_exp);
    int unsigned e;
    e = sel_short ? short_exp : long_exp;
    return (32'd1 << e) - 32'd1;
  endfunction
endpackage

// File: rtl/dt_side_timer.sv
module dt_side_timer #(
  parameter int unsigned LONG_EXP  = 15,
  parameter int unsigned SHORT_EXP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic collect,
  input  logic sel_short,
  output logic busy,
  output logic expire,
  output logic discard
);
  localparam int unsigned CNT_W = (LONG_EXP > SHORT_EXP) ? LONG_EXP : SHORT_EXP;

  logic [CNT_W-1:0] cnt_q;

  assign expire = busy && (cnt_q == '0) && !collect && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      discard <= 1'b0;
    end else begin
      discard <= expire;
      if (collect) begin
        busy <= 1'b0;
      end else if (start) begin
        busy  <= 1'b1;
        cnt_q <= CNT_W'(dt_pkg::span_m1(sel_short, LONG_EXP, SHORT_EXP));
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dt_ctrl_reg.sv
module dt_ctrl_reg #(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             any_expire,
  output logic [REG_W-1:0] rd_data,
  output logic             psel,
  output logic             ssel,
  output logic             serr_en,
  output logic             fwd_en
);
  import dt_pkg::*;

  localparam logic [REG_W-1:0] RW_MASK =
    REG_W'((1 << FWD_BIT) | (1 << PSEL_BIT) | (1 << SSEL_BIT) | (1 << SERR_BIT));

  logic [REG_W-1:0] cfg_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= (cfg_q & ~RW_MASK) | (wr_data & RW_MASK);
      if (any_expire)                     flag_q <= 1'b1;
      else if (wr_en && wr_data[FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data           = cfg_q;
    rd_data[FLAG_BIT] = flag_q;
  end

  assign psel    = cfg_q[PSEL_BIT];
  assign ssel    = cfg_q[SSEL_BIT];
  assign serr_en = cfg_q[SERR_BIT];
  assign fwd_en  = cfg_q[FWD_BIT];
endmodule

// File: rtl/dt_serr_gen.sv
module dt_serr_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_expire,
  input  logic serr_en,
  input  logic fwd_en,
  input  logic sec_serr_in,
  output logic serr_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_req <= 1'b0;
    else        serr_req <= (any_expire && serr_en) || (sec_serr_in && fwd_en);
  end
endmodule

// File: rtl/brdg_discard_timer.sv
module brdg_discard_timer #(
  parameter int unsigned LONG_EXP  = 15,
  parameter int unsigned SHORT_EXP = 10,
  parameter int unsigned REG_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  output logic [REG_W-1:0] ctl_rd_data,
  input  logic             pri_start,
  input  logic             pri_collect,
  input  logic             sec_start,
  input  logic             sec_collect,
  input  logic             sec_serr_in,
  output logic             pri_discard,
  output logic             sec_discard,
  output logic             serr_req
);
  localparam int unsigned NSIDE = 2;

  logic [NSIDE-1:0] side_start, side_collect, side_sel;
  logic [NSIDE-1:0] side_busy, side_expire, side_discard;
  logic             psel, ssel, serr_en, fwd_en, any_expire;

  assign side_start   = {sec_start, pri_start};
  assign side_collect = {sec_collect, pri_collect};
  assign side_sel     = {ssel, psel};
  assign any_expire   = |side_expire;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dt_side_timer #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (side_start[s]),
      .collect  (side_collect[s]),
      .sel_short(side_sel[s]),
      .busy     (side_busy[s]),
      .expire   (side_expire[s]),
      .discard  (side_discard[s])
    );
  end

  dt_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr_en),
    .wr_data   (ctl_wr_data),
    .any_expire(any_expire),
    .rd_data   (ctl_rd_data),
    .psel      (psel),
    .ssel      (ssel),
    .serr_en   (serr_en),
    .fwd_en    (fwd_en)
  );

  dt_serr_gen u_serr (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_expire (any_expire),
    .serr_en    (serr_en),
    .fwd_en     (fwd_en),
    .sec_serr_in(sec_serr_in),
    .serr_req   (serr_req)
  );

  assign pri_discard = side_discard[0];
  assign sec_discard = side_discard[1];
endmodule

// File: rtl/dt_checker.sv
module dt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_clr_wr,
  input logic       flag,
  input logic       serr_en,
  input logic       fwd_en,
  input logic       pri_collect,
  input logic       sec_collect,
  input logic       sec_serr_in,
  input logic       pri_discard,
  input logic       sec_discard,
  input logic       serr_req,
  input logic [1:0] busy
);
  // R3
  pri_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_discard |=> !pri_discard);
  // R7
  pri_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_discard |-> $past(busy[0]));
  // R7
  sec_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_discard |-> $past(busy[1]));
  // R6
  pri_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_collect |=> (!busy[0] && !pri_discard));
  // R6
  sec_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_collect |=> (!busy[1] && !sec_discard));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_discard || sec_discard) |-> flag);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr_wr) |=> flag);
  // R10
  serr_on_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pri_discard || sec_discard) && $past(serr_en)) |-> serr_req);
  // R11
  serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> ($past(sec_serr_in && fwd_en) ||
                  ((pri_discard || sec_discard) && $past(serr_en))));
endmodule

bind brdg_discard_timer dt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flag_clr_wr(ctl_wr_en && ctl_wr_data[10]),
  .flag       (ctl_rd_data[10]),
  .serr_en    (ctl_rd_data[11]),
  .fwd_en     (ctl_rd_data[1]),
  .pri_collect(pri_collect),
  .sec_collect(sec_collect),
  .sec_serr_in(sec_serr_in),
  .pri_discard(pri_discard),
  .sec_discard(sec_discard),
  .serr_req   (serr_req),
  .busy       (side_busy)
);

// File: tb/brdg_discard_timer_bench.sv
module brdg_discard_timer_bench;
  localparam int SHORT = 1024;
  localparam int LONG  = 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [15:0] ctl_wr_data = '0;
  logic [15:0] ctl_rd_data;
  logic        pri_start = 1'b0, pri_collect = 1'b0;
  logic        sec_start = 1'b0, sec_collect = 1'b0;
  logic        sec_serr_in = 1'b0;
  logic        pri_discard, sec_discard, serr_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  brdg_discard_timer u_brdg_discard_timer (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .pri_start(pri_start), .pri_collect(pri_collect),
    .sec_start(sec_start), .sec_collect(sec_collect),
    .sec_serr_in(sec_serr_in),
    .pri_discard(pri_discard), .sec_discard(sec_discard), .serr_req(serr_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
  endtask

  task automatic go(input logic p, input logic s);
    pri_start = p; sec_start = s;
    @(negedge clk);
    pri_start = 1'b0; sec_start = 1'b0;
  endtask

  task automatic count_disc(input int n, output int pc, output int sc);
    pc = 0; sc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pri_discard) pc++;
      if (sec_discard) sc++;
    end
  endtask

  task automatic t_reset;
    check("R1 rd", ctl_rd_data, 16'h0000);
    check("R1 disc", {14'b0, sec_discard, pri_discard}, 16'h0);
    check("R1 serr", {15'b0, serr_req}, 16'h0);
  endtask

  task automatic t_regmap;
    wr(16'hFFFF);
    check("R2 readback", ctl_rd_data, 16'h0B02);
    wr(16'h0000);
    check("R2 cleared", ctl_rd_data, 16'h0000);
  endtask

  task automatic t_short_pri;
    int pc, sc;
    wr(16'h0100);
    go(1'b1, 1'b0);
    tick(SHORT - 1);
    check("R3 early", {15'b0, pri_discard}, 16'h0);
    tick(1);
    check("R3 on time", {15'b0, pri_discard}, 16'h1);
    check("R8 flag", ctl_rd_data, 16'h0500);
    check("R10 gated off", {15'b0, serr_req}, 16'h0);
    tick(1);
    check("R3 one cycle", {15'b0, pri_discard}, 16'h0);
    count_disc(1200, pc, sc);
    check("R7 no restart", 16'(pc), 16'h0);
  endtask

  task automatic t_w1c;
    wr(16'h0100);
    check("R9 write0 keeps", ctl_rd_data, 16'h0500);
    wr(16'h0500);
    check("R9 write1 clears", ctl_rd_data, 16'h0100);
  endtask

  task automatic t_serr;
    wr(16'h0900);
    go(1'b1, 1'b0);
    tick(SHORT - 1);
    check("R10 early", {15'b0, serr_req}, 16'h0);
    tick(1);
    check("R10 pulse", {14'b0, serr_req, pri_discard}, 16'h3);
    tick(1);
    check("R10 one cycle", {15'b0, serr_req}, 16'h0);
    wr(16'h0D00);
    check("R10 clr", ctl_rd_data, 16'h0900);
  endtask

  task automatic t_clear_race;
    wr(16'h0100);
    go(1'b1, 1'b0);
    tick(SHORT - 1);
    ctl_wr_en = 1'b1; ctl_wr_data = 16'h0500;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
    check("R9 expiry wins", ctl_rd_data, 16'h0500);
    wr(16'h0500);
    check("R9 cleared after", ctl_rd_data, 16'h0100);
  endtask

  task automatic t_collect;
    int pc, sc;
    go(1'b1, 1'b0);
    tick(500);
    pri_collect = 1'b1; @(negedge clk); pri_collect = 1'b0;
    count_disc(800, pc, sc);
    check("R6 early collect", 16'(pc), 16'h0);
    go(1'b1, 1'b0);
    tick(SHORT - 1);
    pri_collect = 1'b1; @(negedge clk); pri_collect = 1'b0;
    check("R6 collect at expiry", {15'b0, pri_discard}, 16'h0);
    check("R6 no flag", ctl_rd_data, 16'h0100);
    go(1'b1, 1'b0);
    tick(600);
    go(1'b1, 1'b0);
    tick(SHORT - 1);
    check("R6 restart delays", {15'b0, pri_discard}, 16'h0);
    tick(1);
    check("R6 restart expiry", {15'b0, pri_discard}, 16'h1);
    wr(16'h0500);
  endtask

  task automatic t_sides;
    wr(16'h0100);
    go(1'b1, 1'b1);
    tick(SHORT - 1);
    tick(1);
    check("R5 pri short", {14'b0, sec_discard, pri_discard}, 16'h1);
    tick(LONG - SHORT - 1);
    check("R4 sec early", {15'b0, sec_discard}, 16'h0);
    tick(1);
    check("R4 sec long", {14'b0, sec_discard, pri_discard}, 16'h2);
    wr(16'h0500);
  endtask

  task automatic t_sel_change;
    wr(16'h0300);
    go(1'b0, 1'b1);
    tick(10);
    wr(16'h0100);
    tick(SHORT - 12);
    check("R12 short kept early", {15'b0, sec_discard}, 16'h0);
    tick(1);
    check("R12 short kept", {15'b0, sec_discard}, 16'h1);
    wr(16'h0500);
    go(1'b0, 1'b1);
    wr(16'h0300);
    tick(SHORT - 1);
    check("R12 long kept at 1024", {15'b0, sec_discard}, 16'h0);
    tick(LONG - SHORT - 1);
    check("R12 long early", {15'b0, sec_discard}, 16'h0);
    tick(1);
    check("R12 long kept", {15'b0, sec_discard}, 16'h1);
    wr(16'h0400);
  endtask

  task automatic t_forward;
    sec_serr_in = 1'b1; @(negedge clk); sec_serr_in = 1'b0;
    check("R11 blocked", {15'b0, serr_req}, 16'h0);
    wr(16'h0002);
    sec_serr_in = 1'b1; @(negedge clk); sec_serr_in = 1'b0;
    check("R11 forwarded", {15'b0, serr_req}, 16'h1);
    tick(1);
    check("R11 drops", {15'b0, serr_req}, 16'h0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_regmap;
    t_short_pri;
    t_w1c;
    t_serr;
    t_clear_race;
    t_collect;
    t_sides;
    t_sel_change;
    t_forward;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule